// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel bus ports, A and B, in a non-inverting way. Each direction owns a storage register and a capture strobe. A rising strobe edge loads the value present on that side's input bus into its register. The strobe is examined on the system clock, and capture never depends on the enable or direction inputs. An active-low enable and a direction input decide which port drives, if any.

On the driven port, a per-direction select chooses between two sources. One is the live value arriving at the opposite port, which passes through combinationally. The other is the stored register of that direction. The select of the direction that is not active has no effect on any output.

Each tri-state pin group is split into an input bus, an output bus and one output-enable. An output bus reads zero whenever its port is not driving.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both storage registers to zero. Stored-mode outputs therefore read zero until the first capture.
- R2: While `oe_n` is 1, both `a_oe` and `b_oe` are 0 and both output buses read zero.
- R3: A 0-to-1 transition of `cap_a`, seen at a clock edge, loads `a_in` into the A register at that edge. This happens whatever the values of `oe_n` and `dir`.
- R4: A 0-to-1 transition of `cap_b`, seen at a clock edge, loads `b_in` into the B register at that edge. This happens whatever the values of `oe_n` and `dir`.
- R5: With `oe_n`=0, `dir`=1 and `sel_ab`=0, `b_oe`=1, `a_oe`=0 and `b_out` equals `a_in` in the same cycle.
- R6: With `oe_n`=0, `dir`=1 and `sel_ab`=1, `b_out` equals the A register and does not follow changes of `a_in` without a capture.
- R7: With `oe_n`=0, `dir`=0 and `sel_ba`=0, `a_oe`=1, `b_oe`=0 and `a_out` equals `b_in` in the same cycle.
- R8: With `oe_n`=0, `dir`=0 and `sel_ba`=1, `a_out` equals the B register.
- R9: In stored mode, a capture on the active direction's register shows the new value on the driven port right after the capturing clock edge.
- R10: The select of the inactive direction (`sel_ba` when `dir`=1, `sel_ab` when `dir`=0) has no effect on any output.
- R11: A strobe held at 1 captures only once. Input changes while the strobe stays high are not stored.
- R12: `a_oe` and `b_oe` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, strobes sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output enable, 1 isolates both ports |
| dir | input | 1 | 1: B drives (A to B), 0: A drives (B to A) |
| sel_ab | input | 1 | A-to-B source: 0 live A, 1 A register |
| sel_ba | input | 1 | B-to-A source: 0 live B, 1 B register |
| cap_a | input | 1 | A-side capture strobe, rising transition loads |
| cap_b | input | 1 | B-side capture strobe, rising transition loads |
| a_in | input | WIDTH | Value observed on port A |
| a_out | output | WIDTH | Value driven onto port A, zero when idle |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | WIDTH | Value observed on port B |
| b_out | output | WIDTH | Value driven onto port B, zero when idle |
| b_oe | output | 1 | Port B drive enable |

## Verification
The only internal state is the two storage registers and the previous strobe levels. A wrong register value cannot be seen while a port is in transparent mode or isolated. It appears on the driven port as soon as stored mode is selected for that direction, so the bench captures during isolation and in the opposite direction, then reads back in stored mode. A wrong strobe history shows up as a missed capture, or as a repeat capture while the strobe is held high. Either one becomes visible on the cycle right after the clock edge in question.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drv_e;
endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic stb_q;
  logic rise;

  assign rise = stb & ~stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= 1'b0;
      q     <= '0;
    end else begin
      stb_q <= stb;
      if (rise) q <= d;
    end
  end

  // R3 / R4: a detected rising strobe loads the port value
  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (stb && !stb_q) |=> (q == $past(d)));

  // R11: a strobe held high leaves the register untouched
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (stb && stb_q) |=> $stable(q));
endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl
  import xcvr_pkg::*;
(
  input  logic oe_n,
  input  logic dir,
  input  logic sel_ab,
  input  logic sel_ba,
  output drv_e drv,
  output logic use_store
);
  always_comb begin
    drv       = DRV_NONE;
    use_store = 1'b0;
    if (!oe_n) begin
      if (dir) begin
        drv       = DRV_B;
        use_store = sel_ab;
      end else begin
        drv       = DRV_A;
        use_store = sel_ba;
      end
    end
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int WIDTH = 8
) (
  input  logic             en,
  input  logic             use_store,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] out
);
  always_comb begin
    if (!en)            out = '0;
    else if (use_store) out = stored;
    else                out = live;
  end
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             cap_a,
  input  logic             cap_b,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  logic [WIDTH-1:0] reg_a;
  logic [WIDTH-1:0] reg_b;
  drv_e             drv;
  logic             use_store;

  xcvr_capture #(.WIDTH(WIDTH)) u_cap_a (
    .clk(clk), .rst(rst), .stb(cap_a), .d(a_in), .q(reg_a)
  );

  xcvr_capture #(.WIDTH(WIDTH)) u_cap_b (
    .clk(clk), .rst(rst), .stb(cap_b), .d(b_in), .q(reg_b)
  );

  xcvr_drive_ctrl u_ctrl (
    .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .drv(drv), .use_store(use_store)
  );

  assign a_oe = (drv == DRV_A);
  assign b_oe = (drv == DRV_B);

  xcvr_lane #(.WIDTH(WIDTH)) u_lane_ba (
    .en(a_oe), .use_store(use_store), .live(b_in), .stored(reg_b), .out(a_out)
  );

  xcvr_lane #(.WIDTH(WIDTH)) u_lane_ab (
    .en(b_oe), .use_store(use_store), .live(a_in), .stored(reg_a), .out(b_out)
  );

  assert_one_driver_R12: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe));

  assert_isolate_R2: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  assert_pass_ab_R5: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir && !sel_ab) |-> (b_out == a_in && b_oe && !a_oe));

  assert_pass_ba_R7: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !dir && !sel_ba) |-> (a_out == b_in && a_oe && !b_oe));

  assert_stored_follow_R9: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir && sel_ab && $stable(reg_a)) |=>
      ((!oe_n && dir && sel_ab) ? (b_out == $past(b_out) || reg_a != $past(reg_a)) : 1'b1));
endmodule

// File: tb/bidir_latch_xcvr_bench.sv
module bidir_latch_xcvr_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst, oe_n, dir, sel_ab, sel_ba, cap_a, cap_b;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_oe, b_oe;
  int           n_chk = 0;
  int           n_bad = 0;

  always #2.5 clk = ~clk;

  bidir_latch_xcvr #(.WIDTH(W)) u_bidir_latch_xcvr (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab),
    .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b), .a_in(a_in),
    .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic pulse_a(input logic [W-1:0] v);
    @(negedge clk); a_in = v; cap_a = 1'b1;
    @(negedge clk); cap_a = 1'b0;
  endtask

  task automatic pulse_b(input logic [W-1:0] v);
    @(negedge clk); b_in = v; cap_b = 1'b1;
    @(negedge clk); cap_b = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
    cap_a = 1'b0; cap_b = 1'b0; a_in = 8'hA5; b_in = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; settle();
    chk("R1 stored A after reset", b_out, 8'h00);
    dir = 1'b0; settle();
    chk("R1 stored B after reset", a_out, 8'h00);
  endtask

  task automatic t_isolate();
    @(negedge clk); oe_n = 1'b1; dir = 1'b1; sel_ab = 1'b0; settle();
    chk("R2 a_oe", {7'd0, a_oe}, 8'h00);
    chk("R2 b_oe", {7'd0, b_oe}, 8'h00);
    chk("R2 b_out", b_out, 8'h00);
    dir = 1'b0; sel_ba = 1'b0; settle();
    chk("R2 a_out", a_out, 8'h00);
  endtask

  task automatic t_capture_isolated();
    oe_n = 1'b1;
    pulse_a(8'h5A);
    pulse_b(8'hC3);
    @(negedge clk); a_in = 8'h11; b_in = 8'h22;
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; settle();
    chk("R3 A reg captured while isolated", b_out, 8'h5A);
    dir = 1'b0; sel_ba = 1'b1; settle();
    chk("R4 B reg captured while isolated", a_out, 8'hC3);
    chk("R8 a_oe in stored B-to-A", {7'd0, a_oe}, 8'h01);
  endtask

  task automatic t_pass_ab();
    @(negedge clk); oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0;
    for (int i = 0; i < 4; i++) begin
      a_in = 8'h0F << i; settle();
      chk("R5 live A to B", b_out, 8'h0F << i);
    end
    chk("R5 b_oe", {7'd0, b_oe}, 8'h01);
    chk("R5 a_oe", {7'd0, a_oe}, 8'h00);
    chk("R12 single driver", {7'd0, a_oe & b_oe}, 8'h00);
  endtask

  task automatic t_pass_ba();
    @(negedge clk); oe_n = 1'b0; dir = 1'b0; sel_ba = 1'b0;
    for (int i = 0; i < 4; i++) begin
      b_in = 8'h81 ^ (8'h11 * i); settle();
      chk("R7 live B to A", a_out, 8'h81 ^ (8'h11 * i));
    end
    chk("R7 a_oe", {7'd0, a_oe}, 8'h01);
    chk("R7 b_oe", {7'd0, b_oe}, 8'h00);
  endtask

  task automatic t_stored_ab();
    @(negedge clk); oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    a_in = 8'h99; settle();
    chk("R6 stored ignores live A", b_out, 8'h5A);
    @(negedge clk); a_in = 8'h3C; cap_a = 1'b1; settle();
    chk("R9 before capture edge", b_out, 8'h5A);
    @(posedge clk); settle();
    chk("R9 after capture edge", b_out, 8'h3C);
    @(negedge clk); a_in = 8'hFF;
    repeat (3) @(posedge clk);
    settle();
    chk("R11 held strobe no recapture", b_out, 8'h3C);
    @(negedge clk); cap_a = 1'b0;
    pulse_a(8'hFF); settle();
    chk("R11 new edge captures", b_out, 8'hFF);
  endtask

  task automatic t_stored_ba();
    @(negedge clk); oe_n = 1'b0; dir = 1'b0; sel_ba = 1'b1;
    b_in = 8'h77; cap_b = 1'b1; settle();
    chk("R8 stored B before edge", a_out, 8'hC3);
    @(posedge clk); settle();
    chk("R9 B capture shows on A", a_out, 8'h77);
    @(negedge clk); cap_b = 1'b0;
  endtask

  task automatic t_inactive_sel();
    @(negedge clk); oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0; a_in = 8'h6E;
    sel_ba = 1'b0; settle();
    chk("R10 sel_ba=0 dir=1 b_out", b_out, 8'h6E);
    sel_ba = 1'b1; settle();
    chk("R10 sel_ba=1 dir=1 b_out", b_out, 8'h6E);
    chk("R10 sel_ba=1 dir=1 a_out", a_out, 8'h00);
    dir = 1'b0; sel_ba = 1'b1; b_in = 8'h01;
    sel_ab = 1'b0; settle();
    chk("R10 sel_ab=0 dir=0 a_out", a_out, 8'h77);
    sel_ab = 1'b1; settle();
    chk("R10 sel_ab=1 dir=0 a_out", a_out, 8'h77);
    chk("R10 sel_ab=1 dir=0 b_out", b_out, 8'h00);
  endtask

  task automatic t_capture_other_dir();
    @(negedge clk); oe_n = 1'b0; dir = 1'b0; sel_ba = 1'b0;
    pulse_a(8'h24);
    @(negedge clk); dir = 1'b1; sel_ab = 1'b1; a_in = 8'h00; settle();
    chk("R3 A captured while A was input-less", b_out, 8'h24);
    pulse_b(8'hE7);
    @(negedge clk); dir = 1'b0; sel_ba = 1'b1; b_in = 8'h00; settle();
    chk("R4 B captured while B was driven", a_out, 8'hE7);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_isolate();
        t_capture_isolated();
        t_pass_ab();
        t_pass_ba();
        t_stored_ab();
        t_stored_ba();
        t_inactive_sel();
        t_capture_other_dir();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule